// File: doc/BRIEF.md
# Packet Channel Control Register

This block is a single byte-wide control register for a multi-channel packet transceiver. The host writes it and reads it back at one bus address. Three of its bits are software strobes: a receive end-of-packet request, a transmit end-of-packet request and a request to send clear-to-send again. Each strobe is presented to its engine as a level. It stays set until that engine returns a one-cycle consume pulse, and then it clears itself.

The other bits choose where the receive channel comes from. Normally an automatic channel hunter supplies the channel number, a channel-valid flag and a receiver-active flag. When dedicated receive is enabled, the channel comes from a 4-bit field in the register, the hunter's flags are ignored, valid and active are forced high, and automatic CTS generation is disabled. A separate priority-select input also makes the register field supply the channel, but it does not force the flags. A half-select input supplies the top bit of the resulting 5-bit timeslot index.

Top module: `pkt_chan_ctrl`

## Requirements
- R1: After a synchronous reset every register bit is 0. A read at address 0x51 returns the register, and a read at any other address returns 0.
- R2: A write at 0x51 uses this bit layout: bit 7 is the RX end-of-packet strobe, bit 6 is the CTS re-request, bit 5 is the TX end-of-packet strobe, bit 4 is dedicated-receive enable, and bits 3..0 are the dedicated channel with bit 3 as MSB. A write to any other address changes nothing.
- R3: Writing 1 to bit 7 raises `rx_eop_req`. It stays high, and a write of 0 to bit 7 leaves it high, until `rx_eop_ack` pulses. It is low in the cycle after that pulse.
- R4: Writing 1 to bit 5 raises `tx_eop_req` under the same hold and clear rules, with `tx_eop_ack` as the consume pulse.
- R5: A pending CTS re-request appears on `cts_resend_req` only while `rx_active` is high. It stays pending until `cts_ack` pulses.
- R6: If `rx_active` is low while the CTS re-request bit is set, the bit clears at the next clock edge and `cts_resend_req` is never asserted for it.
- R7: A write that sets a strobe bit in the same cycle as that bit's consume pulse leaves the bit set.
- R8: While bit 4 is 1, `rx_active` and `rx_chan_valid` are 1 and `cts_auto_en` is 0, whatever the hunter's flags are. While bit 4 is 0, those two outputs follow the hunter's flags and `cts_auto_en` is 1.
- R9: The channel comes from bits 3..0 when bit 4 is 1 or `prio_sel` is 1. Otherwise it comes from `hunt_chan`.
- R10: `rx_slot` equals {`half_sel`, channel}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | 8 | Host bus address |
| host_wr | input | 1 | Host write enable |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data (0 when the address does not match) |
| rx_eop_ack | input | 1 | RX engine consumed the end-of-packet strobe |
| tx_eop_ack | input | 1 | TX engine consumed the end-of-packet strobe |
| cts_ack | input | 1 | RX engine consumed the CTS re-request |
| rx_eop_req | output | 1 | Software receive end-of-packet request |
| tx_eop_req | output | 1 | Software transmit end-of-packet request |
| cts_resend_req | output | 1 | Request to issue another clear-to-send |
| hunt_chan | input | 4 | Channel number from the hunter |
| hunt_valid | input | 1 | Hunter channel-valid flag |
| hunt_active | input | 1 | Hunter receiver-active flag |
| prio_sel | input | 1 | Priority select: take the channel from the register field |
| half_sel | input | 1 | Picks timeslots 0-15 or 16-31 |
| rx_slot | output | 5 | Resolved receive timeslot index |
| rx_chan_valid | output | 1 | Resolved channel-valid |
| rx_active | output | 1 | Resolved receiver-active |
| cts_auto_en | output | 1 | Automatic CTS generation enabled |

## Verification
The hold assertions assume that each consume pulse lasts one cycle and arrives only while its request is visible. The stimulus therefore pulses each acknowledge for a single cycle, and only while the matching request is pending. The CTS drop check assumes the hunter's active flag does not toggle in the same cycle the host sets the re-request. The bench changes hunter flags only between writes, so this holds.

// File: rtl/pkt_ctrl_pkg.sv
package pkt_ctrl_pkg;

    localparam int unsigned CHAN_W  = 4;
    localparam int unsigned SLOT_W  = CHAN_W + 1;
    localparam int unsigned NUM_STB = 3;

    // Field order follows the host-visible bit positions, MSB first.
    typedef struct packed {
        logic              rx_eop;
        logic              cts_again;
        logic              tx_eop;
        logic              ded_en;
        logic [CHAN_W-1:0] ded_chan;
    } ctrl_reg_t;

    typedef enum int unsigned {
        STB_RX  = 0,
        STB_CTS = 1,
        STB_TX  = 2
    } strobe_e;

    typedef struct packed {
        logic [SLOT_W-1:0] slot;
        logic              valid;
        logic              active;
        logic              cts_en;
    } rx_sel_t;

    function automatic logic [SLOT_W-1:0] make_slot(input logic half,
                                                    input logic [CHAN_W-1:0] ch);
        return {half, ch};
    endfunction

endpackage

// File: rtl/pkt_host_port.sv
module pkt_host_port
    import pkt_ctrl_pkg::*;
#(
    parameter int unsigned   ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR = 'h51
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_i,
    input  logic [7:0]        wdata_i,
    input  ctrl_reg_t         reg_i,
    output logic              wr_hit_o,
    output ctrl_reg_t         wval_o,
    output logic [7:0]        rdata_o
);
    logic hit;

    always_comb begin
        hit      = (addr_i == REG_ADDR);
        wr_hit_o = hit & wr_i;
        wval_o   = ctrl_reg_t'(wdata_i);
        rdata_o  = hit ? 8'(reg_i) : 8'h00;
    end
endmodule

// File: rtl/pkt_strobe_bit.sv
module pkt_strobe_bit (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic consume_i,
    input  logic drop_i,
    output logic bit_o
);
    logic bit_q;

    always_ff @(posedge clk) begin
        if (rst)                     bit_q <= 1'b0;
        else if (set_i)              bit_q <= 1'b1;
        else if (consume_i | drop_i) bit_q <= 1'b0;
    end

    assign bit_o = bit_q;

    // R7
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        set_i |=> bit_o);
endmodule

// File: rtl/pkt_chan_resolve.sv
module pkt_chan_resolve
    import pkt_ctrl_pkg::*;
(
    input  logic              ded_en_i,
    input  logic [CHAN_W-1:0] ded_chan_i,
    input  logic              prio_i,
    input  logic              half_i,
    input  logic [CHAN_W-1:0] hunt_chan_i,
    input  logic              hunt_valid_i,
    input  logic              hunt_active_i,
    output rx_sel_t           sel_o
);
    logic              use_field;
    logic [CHAN_W-1:0] chan;

    always_comb begin
        use_field     = ded_en_i | prio_i;
        chan          = use_field ? ded_chan_i : hunt_chan_i;
        sel_o.slot    = make_slot(half_i, chan);
        sel_o.valid   = ded_en_i | hunt_valid_i;
        sel_o.active  = ded_en_i | hunt_active_i;
        sel_o.cts_en  = ~ded_en_i;
    end
endmodule

// File: rtl/pkt_chan_ctrl.sv
module pkt_chan_ctrl
    import pkt_ctrl_pkg::*;
#(
    parameter int unsigned       ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR = 'h51
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              host_wr,
    input  logic [7:0]        host_wdata,
    output logic [7:0]        host_rdata,
    input  logic              rx_eop_ack,
    input  logic              tx_eop_ack,
    input  logic              cts_ack,
    output logic              rx_eop_req,
    output logic              tx_eop_req,
    output logic              cts_resend_req,
    input  logic [CHAN_W-1:0] hunt_chan,
    input  logic              hunt_valid,
    input  logic              hunt_active,
    input  logic              prio_sel,
    input  logic              half_sel,
    output logic [SLOT_W-1:0] rx_slot,
    output logic              rx_chan_valid,
    output logic              rx_active,
    output logic              cts_auto_en
);
    logic              wr_hit;
    ctrl_reg_t         wval;
    ctrl_reg_t         reg_q;
    rx_sel_t           sel;
    logic              ded_en_q;
    logic [CHAN_W-1:0] ded_chan_q;
    logic [NUM_STB-1:0] stb_set, stb_cons, stb_drop, stb_bit;

    pkt_host_port #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_host (
        .addr_i   (host_addr),
        .wr_i     (host_wr),
        .wdata_i  (host_wdata),
        .reg_i    (reg_q),
        .wr_hit_o (wr_hit),
        .wval_o   (wval),
        .rdata_o  (host_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ded_en_q   <= 1'b0;
            ded_chan_q <= '0;
        end else if (wr_hit) begin
            ded_en_q   <= wval.ded_en;
            ded_chan_q <= wval.ded_chan;
        end
    end

    always_comb begin
        stb_set[STB_RX]   = wr_hit & wval.rx_eop;
        stb_set[STB_CTS]  = wr_hit & wval.cts_again;
        stb_set[STB_TX]   = wr_hit & wval.tx_eop;
        stb_cons[STB_RX]  = rx_eop_ack;
        stb_cons[STB_CTS] = cts_ack;
        stb_cons[STB_TX]  = tx_eop_ack;
        stb_drop          = '0;
        stb_drop[STB_CTS] = ~sel.active;
    end

    for (genvar g = 0; g < NUM_STB; g++) begin : g_stb
        pkt_strobe_bit u_bit (
            .clk       (clk),
            .rst       (rst),
            .set_i     (stb_set[g]),
            .consume_i (stb_cons[g]),
            .drop_i    (stb_drop[g]),
            .bit_o     (stb_bit[g])
        );
    end

    always_comb begin
        reg_q.rx_eop    = stb_bit[STB_RX];
        reg_q.cts_again = stb_bit[STB_CTS];
        reg_q.tx_eop    = stb_bit[STB_TX];
        reg_q.ded_en    = ded_en_q;
        reg_q.ded_chan  = ded_chan_q;
    end

    pkt_chan_resolve u_res (
        .ded_en_i      (ded_en_q),
        .ded_chan_i    (ded_chan_q),
        .prio_i        (prio_sel),
        .half_i        (half_sel),
        .hunt_chan_i   (hunt_chan),
        .hunt_valid_i  (hunt_valid),
        .hunt_active_i (hunt_active),
        .sel_o         (sel)
    );

    assign rx_slot        = sel.slot;
    assign rx_chan_valid  = sel.valid;
    assign rx_active      = sel.active;
    assign cts_auto_en    = sel.cts_en;
    assign rx_eop_req     = stb_bit[STB_RX];
    assign tx_eop_req     = stb_bit[STB_TX];
    assign cts_resend_req = stb_bit[STB_CTS] & sel.active;

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (reg_q == '0));

    // R3
    rx_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_eop_req && !rx_eop_ack) |=> rx_eop_req);

    // R4
    tx_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_eop_req && !tx_eop_ack) |=> tx_eop_req);

    // R5
    cts_active_chk: assert property (@(posedge clk) disable iff (rst)
        cts_resend_req |-> rx_active);

    // R6
    cts_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_q.cts_again && !rx_active && !stb_set[STB_CTS]) |=> !reg_q.cts_again);

    // R8
    ded_force_chk: assert property (@(posedge clk) disable iff (rst)
        ded_en_q |-> (rx_active && rx_chan_valid && !cts_auto_en));

    // R10
    half_bit_chk: assert property (@(posedge clk) disable iff (rst)
        rx_slot[SLOT_W-1] == half_sel);
endmodule

// File: tb/test_pkt_chan_ctrl.sv
module test_pkt_chan_ctrl;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] host_addr = 8'h51;
    logic       host_wr = 1'b0;
    logic [7:0] host_wdata = 8'h00;
    logic [7:0] host_rdata;
    logic       rx_eop_ack = 1'b0, tx_eop_ack = 1'b0, cts_ack = 1'b0;
    logic       rx_eop_req, tx_eop_req, cts_resend_req;
    logic [3:0] hunt_chan = 4'h0;
    logic       hunt_valid = 1'b0, hunt_active = 1'b0;
    logic       prio_sel = 1'b0, half_sel = 1'b0;
    logic [4:0] rx_slot;
    logic       rx_chan_valid, rx_active, cts_auto_en;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // behavioural reference state
    bit       m_rx, m_cts, m_tx, m_ded;
    bit [3:0] m_chan;

    always #4 clk = ~clk;

    pkt_chan_ctrl i_pkt_chan_ctrl (
        .clk(clk), .rst(rst),
        .host_addr(host_addr), .host_wr(host_wr), .host_wdata(host_wdata),
        .host_rdata(host_rdata),
        .rx_eop_ack(rx_eop_ack), .tx_eop_ack(tx_eop_ack), .cts_ack(cts_ack),
        .rx_eop_req(rx_eop_req), .tx_eop_req(tx_eop_req),
        .cts_resend_req(cts_resend_req),
        .hunt_chan(hunt_chan), .hunt_valid(hunt_valid), .hunt_active(hunt_active),
        .prio_sel(prio_sel), .half_sel(half_sel),
        .rx_slot(rx_slot), .rx_chan_valid(rx_chan_valid),
        .rx_active(rx_active), .cts_auto_en(cts_auto_en)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // reference update
    always @(posedge clk) begin
        bit wr, act_now;
        wr      = host_wr && (host_addr == 8'h51);
        act_now = m_ded || hunt_active;
        if (rst) begin
            m_rx <= 0; m_cts <= 0; m_tx <= 0; m_ded <= 0; m_chan <= 0;
        end else begin
            if (wr && host_wdata[7]) m_rx <= 1; else if (rx_eop_ack) m_rx <= 0;
            if (wr && host_wdata[6]) m_cts <= 1; else if (cts_ack || !act_now) m_cts <= 0;
            if (wr && host_wdata[5]) m_tx <= 1; else if (tx_eop_ack) m_tx <= 0;
            if (wr) begin m_ded <= host_wdata[4]; m_chan <= host_wdata[3:0]; end
        end
    end

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        bit       e_act, e_val;
        bit [3:0] e_ch;
        bit [7:0] e_rd;
        if (!rst && !done) begin
            e_act = m_ded || hunt_active;
            e_val = m_ded || hunt_valid;
            e_ch  = (m_ded || prio_sel) ? m_chan : hunt_chan;
            e_rd  = (host_addr == 8'h51) ? {m_rx, m_cts, m_tx, m_ded, m_chan} : 8'h00;
            chk("R2 rdata", host_rdata, e_rd);
            chk("R3 rx_eop_req", rx_eop_req, m_rx);
            chk("R4 tx_eop_req", tx_eop_req, m_tx);
            chk("R5 cts_resend_req", cts_resend_req, m_cts && e_act);
            chk("R8 rx_active", rx_active, e_act);
            chk("R8 rx_chan_valid", rx_chan_valid, e_val);
            chk("R8 cts_auto_en", cts_auto_en, !m_ded);
            chk("R10 rx_slot", rx_slot, {half_sel, e_ch});
        end
    end

    task automatic step();
        @(posedge clk); #2;
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        step();
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        step();
        host_wr = 1'b0; host_addr = 8'h51;
    endtask

    task automatic pulse(ref logic sig);
        sig = 1'b1; step(); sig = 1'b0;
    endtask

    initial begin
        repeat (3) step();
        rst = 1'b0;
        @(negedge clk);
        chk("R1 reset rdata", host_rdata, 8'h00);
        chk("R1 reset rx_eop_req", rx_eop_req, 1'b0);
        host_addr = 8'h50; @(negedge clk);
        chk("R1 other address reads zero", host_rdata, 8'h00);
        host_addr = 8'h51;

        // dedicated mode, channel 0xA, upper half
        half_sel = 1'b1;
        wr(8'h51, 8'h1A);
        @(negedge clk);
        chk("R2 layout readback", host_rdata, 8'h1A);
        chk("R10 dedicated slot", rx_slot, 5'h1A);
        chk("R8 forced active", {rx_active, rx_chan_valid, cts_auto_en}, 3'b110);

        // write to another address ignored
        wr(8'h50, 8'hFF);
        @(negedge clk);
        chk("R2 foreign write ignored", host_rdata, 8'h1A);

        // normal hunt path
        half_sel = 1'b0; hunt_chan = 4'h5; hunt_active = 1'b1; hunt_valid = 1'b1;
        wr(8'h51, 8'h07);
        @(negedge clk);
        chk("R9 hunter channel", rx_slot, 5'h05);
        prio_sel = 1'b1; @(negedge clk);
        chk("R9 priority override", rx_slot, 5'h07);
        chk("R8 priority keeps cts auto", cts_auto_en, 1'b1);
        prio_sel = 1'b0;

        // RX end-of-packet strobe
        wr(8'h51, 8'h87);
        repeat (3) step();
        wr(8'h51, 8'h07);
        @(negedge clk);
        chk("R3 held after zero write", rx_eop_req, 1'b1);
        step(); pulse(rx_eop_ack);
        @(negedge clk);
        chk("R3 cleared by consume", rx_eop_req, 1'b0);

        // TX end-of-packet strobe
        wr(8'h51, 8'h27);
        repeat (2) step();
        @(negedge clk);
        chk("R4 pending", tx_eop_req, 1'b1);
        step(); pulse(tx_eop_ack);
        @(negedge clk);
        chk("R4 cleared by consume", tx_eop_req, 1'b0);

        // CTS re-request while active
        wr(8'h51, 8'h47);
        @(negedge clk);
        chk("R5 issued while active", cts_resend_req, 1'b1);
        step(); step();
        chk("R5 still pending", cts_resend_req, 1'b1);
        pulse(cts_ack);
        @(negedge clk);
        chk("R5 cleared by consume", cts_resend_req, 1'b0);

        // CTS re-request while inactive: dropped
        hunt_active = 1'b0;
        wr(8'h51, 8'h47);
        @(negedge clk);
        chk("R6 never issued", cts_resend_req, 1'b0);
        step();
        @(negedge clk);
        chk("R6 bit dropped", host_rdata[6], 1'b0);
        hunt_active = 1'b1;

        // write wins over same-cycle consume
        wr(8'h51, 8'h87);
        step();
        host_wdata = 8'h87; host_wr = 1'b1; rx_eop_ack = 1'b1;
        step();
        host_wr = 1'b0; rx_eop_ack = 1'b0;
        @(negedge clk);
        chk("R7 write wins", rx_eop_req, 1'b1);
        step(); pulse(rx_eop_ack);

        // dedicated mode ignores hunter flags
        wr(8'h51, 8'h13);
        hunt_active = 1'b0; hunt_valid = 1'b0; hunt_chan = 4'hC;
        @(negedge clk);
        chk("R8 flags ignored", {rx_active, rx_chan_valid}, 2'b11);
        chk("R9 dedicated channel", rx_slot, 5'h03);

        repeat (3) step();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule